// File: doc/BRIEF.md
# Multiplier Underflow Finishing Stage

This block finishes a single-precision multiply whose own rounding step was skipped. It takes the raw product mantissa, a guard bit, a sticky bit and the signed sum exponent. It sorts the operation into one of six classes by mantissa range and exponent sign. Each class has its own way of aligning the mantissa: it is left where it is, shifted right to denormalize it, or shifted left to renormalize it. The aligned value is then rounded to nearest, ties to even, and packed into a 32-bit IEEE single-precision word. That word may be normal, subnormal, zero or infinity.

The product mantissa is 25 bits wide. Bit 24 weighs 2, bit 23 weighs 1 and bit 0 weighs 2^-23. The guard bit weighs 2^-24, and the sticky bit stands for anything nonzero below the guard bit. The exponent input is the biased sum of the operands' stored exponent fields minus the bias, so a value of 1 to 254 is a normal exponent field. If an operand was subnormal, its stored field 0 stands for 1, so a mantissa below 1 is taken to carry exponent e+1. Tininess is judged on the rounded result. A value that rounds up out of the subnormal range therefore leaves as the smallest normal number and raises no underflow.

Top module: `mul_subnorm_finish`

## Requirements
- R1: A sample taken with `in_valid` high appears on the outputs two clock edges later with `out_valid` high. A synchronous reset clears `out_valid`, `out_result` and `out_underflow` to zero.
- R2: The result sign is the XOR of the two operand signs, including on zero results.
- R3: Class 0 (mantissa in [1,2) and e > 0): the exponent field is e and the fraction is mantissa bits 22:0, rounded with the guard and sticky bits. A mantissa of 2 or more with e >= 0 is shifted right by one and gets exponent field e+1; its bit 0 becomes the round bit.
- R4: Class 1 (mantissa in [1,2) and e <= 0): the mantissa is shifted right by 1-e into a subnormal result. The guard bit and the shifted-out bits feed the sticky.
- R5: Class 2 (mantissa of 2 or more and e < 0): the mantissa is shifted right by 1-e into a subnormal. Mantissa bit 0 takes part in the rounding, so a tie with bit 0 clear rounds to even, and the same value with bit 0 set rounds up.
- R6: Class 3 (mantissa below 1 and e = 0): the mantissa bits 23:0 are already aligned and become the subnormal fraction with no shift. Only rounding is applied.
- R7: Class 4 (mantissa below 1 and e < 0): the mantissa is shifted right by -e, then rounded.
- R8: Class 5 (mantissa below 1 and e > 0): let z be the number of leading zeros of {mantissa[23:0], guard}. If z <= e, the mantissa is shifted left by z and the exponent field is e+1-z. Otherwise it is shifted left by e and the result is subnormal. When bits are shifted in from below, the round bit is 0 and the sticky is the sticky input.
- R9: A mantissa counts as below 1 when `in_no_lead` is high or mantissa bits 24:23 are both zero. With `in_no_lead` high, mantissa bits 24:23 are ignored.
- R10: Rounding is to nearest, ties to even. A carry out of the fraction raises the exponent field, and a subnormal can round up to the smallest normal (0x00800000).
- R11: A right shift of 26 places or more leaves only sticky information, and the result rounds to zero. A shift of exactly 25 with mantissa bit 24 set and lower bits nonzero rounds to the smallest subnormal. A flagged mantissa with a very negative exponent gives zero.
- R12: `out_underflow` is high exactly when the rounded exponent field is 0 and the guard, sticky or any shifted-out bit was nonzero.
- R13: A rounded exponent field of 255 or more produces infinity (exponent all ones, fraction zero) with the result sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is valid |
| in_sign_a | input | 1 | Sign of the first operand |
| in_sign_b | input | 1 | Sign of the second operand |
| in_mant | input | 25 | Pre-rounded product mantissa, two integer bits |
| in_guard | input | 1 | First discarded bit below the mantissa |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_exp | input | 10 | Signed biased sum exponent |
| in_no_lead | input | 1 | Mantissa has no implied leading one |
| out_valid | output | 1 | Result is valid |
| out_result | output | 32 | Single-precision result |
| out_underflow | output | 1 | Tiny and inexact after rounding |

## Verification
The hardest situations to reach are the boundaries between classes, where one extra place of shift decides the rounding. One is a class-1 value at e = 0 whose round-up carries it into the normal range. Another is a class-2 value shifted by exactly 25, where only mantissa bit 24 and the sticky decide between zero and the smallest subnormal. A third is the class-5 split at z = e. The stimulus sets the exponent input to each edge value directly and picks mantissas whose top bit, bit 0 and guard bit form exact ties. The bench's reference model derives every result from the unbounded exponent and never from the class table.

// File: rtl/ufp_pkg.sv
package ufp_pkg;
  typedef enum logic [2:0] {
    UC_NORMAL      = 3'd0,
    UC_UNIT_LOW    = 3'd1,
    UC_WIDE_LOW    = 3'd2,
    UC_SUB_ALIGNED = 3'd3,
    UC_SUB_RIGHT   = 3'd4,
    UC_SUB_LEFT    = 3'd5
  } ucase_t;
endpackage

// File: rtl/ufp_classify.sv
module ufp_classify #(
  parameter int FRAC_W   = 23,
  parameter int EXP_IN_W = 10
) (
  input  logic [FRAC_W+1:0]          mant,
  input  logic                       guard,
  input  logic                       no_lead,
  input  logic signed [EXP_IN_W-1:0] exp_in,
  output logic [FRAC_W+1:0]          mant_eff,
  output ufp_pkg::ucase_t            ucase,
  output logic                       shl,
  output logic [$clog2(FRAC_W+5)-1:0] amt,
  output logic [EXP_IN_W:0]          eo
);
  import ufp_pkg::*;
  localparam int MANT_W = FRAC_W + 2;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int D_W    = MANT_W + 1;
  localparam int RMAX   = D_W + 1;
  localparam int SH_W   = $clog2(FRAC_W + 5);
  localparam int EO_W   = EXP_IN_W + 1;
  localparam int LZ_W   = $clog2(SIG_W + 2);

  logic below, above, nonpos;
  logic signed [EXP_IN_W:0] ex;
  logic signed [EXP_IN_W:0] lz_x;
  logic [LZ_W-1:0] lz;
  logic [SIG_W:0] dvec;

  function automatic logic [SH_W-1:0] clamp_r(input logic signed [EXP_IN_W:0] k);
    if (k > RMAX) return SH_W'(RMAX);
    return SH_W'(k);
  endfunction

  assign below    = no_lead | ~(mant[MANT_W-1] | mant[MANT_W-2]);
  assign above    = ~below & mant[MANT_W-1];
  assign mant_eff = below ? {2'b00, mant[MANT_W-3:0]} : mant;
  assign ex       = {exp_in[EXP_IN_W-1], exp_in};
  assign nonpos   = (ex <= 0);
  assign dvec     = {mant_eff[SIG_W-1:0], guard};

  always_comb begin
    lz = LZ_W'(SIG_W + 1);
    for (int i = 0; i <= SIG_W; i++) begin
      if (dvec[i]) lz = LZ_W'(SIG_W - i);
    end
  end

  assign lz_x = (EXP_IN_W+1)'(lz);

  always_comb begin
    ucase = UC_NORMAL;
    shl   = 1'b0;
    amt   = '0;
    eo    = '0;
    if (!below) begin
      if (above) begin
        if (ex >= 0) begin
          ucase = UC_NORMAL;
          amt   = SH_W'(1);
          eo    = EO_W'(ex + 1);
        end else begin
          ucase = UC_WIDE_LOW;
          amt   = clamp_r(1 - ex);
        end
      end else if (!nonpos) begin
        ucase = UC_NORMAL;
        eo    = EO_W'(ex);
      end else begin
        ucase = UC_UNIT_LOW;
        amt   = clamp_r(1 - ex);
      end
    end else begin
      if (ex == 0) begin
        ucase = UC_SUB_ALIGNED;
      end else if (ex < 0) begin
        ucase = UC_SUB_RIGHT;
        amt   = clamp_r(-ex);
      end else begin
        ucase = UC_SUB_LEFT;
        shl   = 1'b1;
        if (lz == LZ_W'(SIG_W + 1)) begin
          amt = '0;
        end else if (lz_x <= ex) begin
          amt = SH_W'(lz);
          eo  = EO_W'(ex + 1 - lz_x);
        end else begin
          amt = SH_W'(ex);
        end
      end
    end
  end
endmodule

// File: rtl/ufp_align.sv
module ufp_align #(
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W+1:0]           mant_eff,
  input  logic                        guard,
  input  logic                        sticky,
  input  logic                        shl,
  input  logic [$clog2(FRAC_W+5)-1:0] amt,
  output logic [FRAC_W:0]             sig,
  output logic                        rnd,
  output logic                        stk,
  output logic                        spill
);
  localparam int MANT_W = FRAC_W + 2;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int D_W    = MANT_W + 1;

  logic [D_W-1:0]   dv;
  logic [2*D_W-1:0] wide;
  logic [D_W-1:0]   lft;

  assign dv   = {mant_eff, guard};
  assign wide = {dv, {D_W{1'b0}}} >> amt;
  assign lft  = dv << amt;

  always_comb begin
    if (shl) begin
      sig   = lft[SIG_W:1];
      rnd   = lft[0];
      stk   = sticky;
      spill = lft[D_W-1];
    end else begin
      sig   = wide[2*D_W-2 -: SIG_W];
      rnd   = wide[D_W];
      stk   = (|wide[D_W-1:0]) | sticky;
      spill = wide[2*D_W-1];
    end
  end
endmodule

// File: rtl/ufp_round.sv
module ufp_round #(
  parameter int FRAC_W   = 23,
  parameter int EXP_IN_W = 10,
  parameter int EF_W     = 8
) (
  input  logic                 sign,
  input  logic [FRAC_W-1:0]    frac,
  input  logic                 rnd,
  input  logic                 stk,
  input  logic [EXP_IN_W:0]    eo,
  output logic [EF_W+FRAC_W:0] result,
  output logic                 uf
);
  localparam int EO_W = EXP_IN_W + 1;
  localparam int P_W  = EO_W + FRAC_W;
  localparam int EMAX = (1 << EF_W) - 1;

  logic           inc;
  logic [P_W-1:0] sum;
  logic [EO_W-1:0] ef;

  assign inc = rnd & (stk | frac[0]);
  assign sum = {eo, frac} + P_W'(inc);
  assign ef  = sum[P_W-1:FRAC_W];

  always_comb begin
    if (ef >= EO_W'(EMAX)) begin
      result = {sign, {EF_W{1'b1}}, {FRAC_W{1'b0}}};
      uf     = 1'b0;
    end else begin
      result = {sign, ef[EF_W-1:0], sum[FRAC_W-1:0]};
      uf     = (ef == '0) & (rnd | stk);
    end
  end
endmodule

// File: rtl/mul_subnorm_finish.sv
module mul_subnorm_finish #(
  parameter int FRAC_W   = 23,
  parameter int EXP_IN_W = 10,
  parameter int EF_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       in_sign_a,
  input  logic                       in_sign_b,
  input  logic [FRAC_W+1:0]          in_mant,
  input  logic                       in_guard,
  input  logic                       in_sticky,
  input  logic signed [EXP_IN_W-1:0] in_exp,
  input  logic                       in_no_lead,
  output logic                       out_valid,
  output logic [EF_W+FRAC_W:0]       out_result,
  output logic                       out_underflow
);
  import ufp_pkg::*;
  localparam int SIG_W = FRAC_W + 1;
  localparam int SH_W  = $clog2(FRAC_W + 5);
  localparam int EO_W  = EXP_IN_W + 1;
  localparam int OUT_W = 1 + EF_W + FRAC_W;

  logic [FRAC_W+1:0] mant_eff;
  ucase_t            ucase;
  logic              shl, spill;
  logic [SH_W-1:0]   amt;
  logic [EO_W-1:0]   eo;
  logic [SIG_W-1:0]  sig;
  logic              rnd, stk;

  logic              s1_valid, s1_sign, s1_rnd, s1_stk;
  logic [SIG_W-1:0]  s1_sig;
  logic [EO_W-1:0]   s1_eo;
  ucase_t            s1_case;

  logic [OUT_W-1:0]  res_w;
  logic              uf_w;

  ufp_classify #(.FRAC_W(FRAC_W), .EXP_IN_W(EXP_IN_W)) u_classify (
    .mant(in_mant), .guard(in_guard), .no_lead(in_no_lead), .exp_in(in_exp),
    .mant_eff(mant_eff), .ucase(ucase), .shl(shl), .amt(amt), .eo(eo)
  );

  ufp_align #(.FRAC_W(FRAC_W)) u_align (
    .mant_eff(mant_eff), .guard(in_guard), .sticky(in_sticky), .shl(shl),
    .amt(amt), .sig(sig), .rnd(rnd), .stk(stk), .spill(spill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_sig   <= '0;
      s1_rnd   <= 1'b0;
      s1_stk   <= 1'b0;
      s1_eo    <= '0;
      s1_case  <= UC_NORMAL;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_sign <= in_sign_a ^ in_sign_b;
        s1_sig  <= sig;
        s1_rnd  <= rnd;
        s1_stk  <= stk;
        s1_eo   <= eo;
        s1_case <= ucase;
      end
    end
  end

  ufp_round #(.FRAC_W(FRAC_W), .EXP_IN_W(EXP_IN_W), .EF_W(EF_W)) u_round (
    .sign(s1_sign), .frac(s1_sig[FRAC_W-1:0]), .rnd(s1_rnd), .stk(s1_stk),
    .eo(s1_eo), .result(res_w), .uf(uf_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_underflow <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_result    <= res_w;
        out_underflow <= uf_w;
      end
    end
  end

  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (rst) in_valid |=> s1_valid); // R1
  AST_STAGE_TWO: assert property (@(posedge clk) disable iff (rst) s1_valid |=> out_valid); // R1
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_result[OUT_W-1] == $past(in_sign_a ^ in_sign_b, 2)); // R2
  AST_NO_SPILL: assert property (@(posedge clk) disable iff (rst) in_valid |-> !spill); // R8
  AST_HIDDEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    s1_valid |-> ((s1_eo != '0) == s1_sig[SIG_W-1])); // R4
  AST_LEFT_NORMAL_EXP: assert property (@(posedge clk) disable iff (rst)
    s1_valid && s1_case == UC_SUB_LEFT && s1_eo != '0 |-> !s1_rnd); // R8
  AST_UF_TINY: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_underflow |-> out_result[OUT_W-2 -: EF_W] == '0); // R12
  AST_INF_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_valid && (&out_result[OUT_W-2 -: EF_W]) |-> out_result[FRAC_W-1:0] == '0); // R13
endmodule

// File: tb/mul_subnorm_finish_tb.sv
module mul_subnorm_finish_tb;
  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_sign_a, in_sign_b, in_guard, in_sticky, in_no_lead;
  logic [24:0] in_mant;
  logic signed [9:0] in_exp;
  logic out_valid, out_underflow;
  logic [31:0] out_result;
  int checks = 0;
  int errors = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  mul_subnorm_finish u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign_a(in_sign_a),
    .in_sign_b(in_sign_b), .in_mant(in_mant), .in_guard(in_guard),
    .in_sticky(in_sticky), .in_exp(in_exp), .in_no_lead(in_no_lead),
    .out_valid(out_valid), .out_result(out_result), .out_underflow(out_underflow)
  );

  function automatic logic [32:0] model(input logic [24:0] m, input logic g,
      input logic st, input logic flag, input int e, input logic sgn);
    logic below;
    logic [24:0] mm;
    longint n, q, r, t;
    int x, p, ee, sh, field;
    logic nrm;
    below = flag || (m[24:23] == 2'b00);
    mm = below ? {2'b00, m[22:0]} : m;
    x = below ? e + 1 : e;
    n = longint'({mm, g});
    if (n == 0) return {st, sgn, 31'd0};
    p = 0;
    for (int i = 0; i < 26; i++) if (n[i]) p = i;
    ee = x + p - 24;
    nrm = (ee >= 1);
    sh = nrm ? p - 23 : 2 - x;
    if (sh >= 40) begin
      q = 0; r = 0; t = 1;
    end else if (sh > 0) begin
      q = n >> sh;
      r = (n >> (sh - 1)) & 1;
      t = (((n & ((longint'(1) << (sh - 1)) - 1)) != 0) || st) ? 1 : 0;
    end else begin
      q = n << (-sh); r = 0; t = longint'(st);
    end
    if (r == 1 && (t == 1 || q[0])) q = q + 1;
    if (nrm) begin
      if (q >= (longint'(1) << 24)) begin q = q >> 1; ee = ee + 1; end
      field = ee;
    end else begin
      field = (q >= (longint'(1) << 23)) ? 1 : 0;
    end
    if (field >= 255) return {1'b0, sgn, 8'hFF, 23'd0};
    return {(field == 0 && (r == 1 || t == 1)), sgn, field[7:0], q[22:0]};
  endfunction

  task automatic run(input string req, input logic [24:0] m, input logic g,
      input logic st, input logic flag, input int e, input logic sa,
      input logic sb, output logic [31:0] res);
    logic [32:0] exp_v;
    exp_v = model(m, g, st, flag, e, sa ^ sb);
    @(negedge clk);
    in_valid = 1'b1; in_mant = m; in_guard = g; in_sticky = st;
    in_no_lead = flag; in_exp = 10'(e); in_sign_a = sa; in_sign_b = sb;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (!out_valid || out_result !== exp_v[31:0] || out_underflow !== exp_v[32]) begin
      errors++;
      $display("FAIL %s: valid=%0b result=%h uf=%0b expected result=%h uf=%0b",
               req, out_valid, out_result, out_underflow, exp_v[31:0], exp_v[32]);
    end
    res = out_result;
  endtask

  task automatic lit(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd0 || out_underflow !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: valid=%0b result=%h expected 0 0", out_valid, out_result);
    end
  endtask

  task automatic t_case0;
    logic [31:0] a;
    run("R3 normal 1.5", 25'h0C00000, 0, 0, 0, 100, 1, 1, a);
    lit("R3 normal literal", a, 32'h32400000);
    run("R3 wide normal", 25'h1800000, 0, 0, 0, 0, 0, 0, a);
    lit("R3 wide literal", a, 32'h00C00000);
    run("R10 tie odd", 25'h0800001, 1, 0, 0, 50, 0, 0, a);
    run("R10 tie even", 25'h0800000, 1, 0, 0, 50, 0, 0, a);
    lit("R10 tie even literal", a, 32'h19000000);
  endtask

  task automatic t_case1;
    logic [31:0] a;
    run("R4 e zero", 25'h0800000, 0, 0, 0, 0, 0, 1, a);
    lit("R4 literal", a, 32'h80400000);
    run("R4 e neg", 25'h0ABCDEF, 1, 1, 0, -5, 0, 0, a);
    run("R10 carry to normal", 25'h0FFFFFF, 1, 0, 0, 0, 0, 0, a);
    lit("R10 carry literal", a, 32'h00800000);
  endtask

  task automatic t_case2;
    logic [31:0] a;
    run("R5 tie lsb clear", 25'h1000002, 0, 0, 0, -1, 0, 0, a);
    lit("R5 tie literal", a, 32'h00400000);
    run("R5 lsb set", 25'h1000003, 0, 0, 0, -1, 0, 0, a);
    lit("R5 lsb literal", a, 32'h00400001);
  endtask

  task automatic t_case3_4;
    logic [31:0] a;
    run("R6 aligned", 25'h0123456, 0, 0, 1, 0, 0, 0, a);
    lit("R6 literal", a, 32'h00123456);
    run("R7 right", 25'h0400000, 0, 0, 1, -4, 0, 0, a);
    lit("R7 literal", a, 32'h00040000);
    run("R7 sticky", 25'h0400007, 1, 1, 1, -3, 0, 0, a);
  endtask

  task automatic t_case5;
    logic [31:0] a;
    run("R8 full normalize", 25'h0100000, 0, 0, 1, 10, 0, 0, a);
    lit("R8 normal literal", a, 32'h04000000);
    run("R8 partial", 25'h0010000, 0, 0, 1, 2, 0, 0, a);
    lit("R8 partial literal", a, 32'h00040000);
    run("R8 boundary z equal e", 25'h0100000, 1, 1, 1, 3, 0, 0, a);
    run("R8 zero mantissa", 25'h0000000, 0, 0, 1, 30, 0, 0, a);
  endtask

  task automatic t_flag;
    logic [31:0] a, b;
    run("R9 top bits set", 25'h1834567, 1, 0, 1, -2, 0, 0, a);
    run("R9 top bits clear", 25'h0034567, 1, 0, 1, -2, 0, 0, b);
    lit("R9 ignored top bits", a, b);
  endtask

  task automatic t_collapse;
    logic [31:0] a;
    run("R11 far shift", 25'h0800000, 1, 1, 0, -40, 0, 0, a);
    lit("R11 zero literal", a, 32'h00000000);
    run("R11 shift 25", 25'h1000001, 0, 0, 0, -24, 0, 0, a);
    lit("R11 min subnormal", a, 32'h00000001);
    run("R11 two subnormals", 25'h0000001, 0, 0, 1, -120, 1, 0, a);
    lit("R2 signed zero", a, 32'h80000000);
  endtask

  task automatic t_underflow_overflow;
    logic [31:0] a;
    run("R12 exact subnormal", 25'h0200000, 0, 0, 1, -1, 0, 0, a);
    run("R12 inexact subnormal", 25'h0200000, 0, 1, 1, -1, 0, 0, a);
    run("R13 wide overflow", 25'h1000000, 0, 0, 0, 254, 0, 0, a);
    lit("R13 inf literal", a, 32'h7F800000);
    run("R13 round overflow", 25'h0FFFFFF, 1, 0, 0, 254, 1, 0, a);
    lit("R13 neg inf literal", a, 32'hFF800000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_sign_a = 0; in_sign_b = 0; in_mant = '0;
    in_guard = 0; in_sticky = 0; in_exp = '0; in_no_lead = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_case0();
    t_case1();
    t_case2();
    t_case3_4();
    t_case5();
    t_flag();
    t_collapse();
    t_underflow_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule